// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing half of a simple serial port. It sits between a word-addressed register bus and a byte-wide character interface. Software uses it to set up the port, to read status, to send one character at a time and to collect received characters from a single-entry buffer. It also drives one level interrupt. Bit timing, shifting, deep queues and modem lines belong to other blocks. The baud, FIFO-control and millisecond registers only hold what software writes into them.

Received characters come in through a strobe. The block takes a new character only while its buffer is free, and it signals this on `rxReady`. A break event stores a break marker in the buffer in place of a character. When software writes the transmit-data offset, the byte goes out on the character interface as a one-cycle pulse, and only while the transmitter is enabled. Writing control register 2 with its bit 0 clear performs a software reset of the port state.

Top module: `serial_csr_top`

## Requirements
- R1: After reset the registers read as follows. Status 1 (0x25) = 0x6040. Status 2 (0x26) = 0x4028. Test (0x2D) = 0x0060. Control 2 (0x21) = 0x0001. Control 3 (0x22) = 0x0700. Baud increment (0x29) = 0x0004. Control 1 (0x20) = 0. Modulator (0x2A) = 0. Receive data (0x00) = 0x4000. `irq` and `txValid` are low and `rxReady` is high.
- R2: Writes to control 1 and control 3 (0x20, 0x22), FIFO control (0x24), baud increment (0x29), modulator (0x2A) and millisecond (0x2C) keep the low 16 bits. A read returns those bits, zero-extended.
- R3: A strobe taken while `rxReady` is high does four things. It sets status-1 bit 9 and status-2 bit 0, clears test bit 5 and loads the byte, zero-extended, into the buffer. `rxReady` then goes low.
- R4: A strobe taken with `rxBreak` high loads the buffer with 0x0800 (bit 11) and ignores the byte.
- R5: A receive-data read while test bit 5 is clear returns the buffer with bit 15 set. It also clears status-1 bit 9 and status-2 bit 0 and sets test bit 5. While test bit 5 is set, the same read returns the buffer without bit 15 and changes nothing.
- R6: A strobe that arrives while `rxReady` is low is dropped, and the buffer is unchanged.
- R7: Status 1 is write-1-to-clear, limited to mask 0x9DB0. Status 2 is write-1-to-clear, limited to mask 0xBDD6. Every other status bit ignores the write.
- R8: Writing control 2 with bit 0 = 0 restores the R1 values of every register except FIFO control and millisecond. Control 2 then takes the written value with bit 0 forced to 1. A strobe in that same cycle is dropped.
- R9: `irq` is high exactly when status-1 bit 9 and control-1 bit 9 are both set, or when status-1 bit 13, control-1 bit 13 and control-1 bit 6 are all set.
- R10: A write to 0x10 while control-2 bit 2 is set raises `txValid` for one cycle after the write edge, with `txByte` = data bits 7:0. With bit 2 clear, nothing is sent. Status-1 bit 13 stays set either way.
- R11: Offsets outside the map, including 0x23 and 0x2B, read as 0. Writes to them and to the test register (0x2D) have no effect.
- R12: Read data is registered. `busRdata` changes on the edge that samples a read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| txValid | output | 1 | One-cycle transmit pulse |
| txByte | output | CHAR_W | Transmitted byte |
| rxStrobe | input | 1 | Incoming character or break event |
| rxBreak | input | 1 | Qualifies rxStrobe as a break |
| rxByte | input | CHAR_W | Incoming character |
| rxReady | output | 1 | Buffer free, strobe will be taken |
| irq | output | 1 | Level interrupt |

## Verification
Two things can fall in the same cycle: a receive-data read that empties the buffer, and a new incoming-character strobe. The bench provokes this by raising both in the same cycle while the buffer holds a known character. It expects the read to return that character with bit 15 set. Because the buffer was still full when the strobe arrived, the strobe must be dropped, so a second read has to return the old character without bit 15. The bench also coincides a strobe with a software reset and expects the buffer to come back at its reset value.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

  localparam int REG_W = 16;

  // word offsets
  localparam int OFS_RXD  = 'h00;
  localparam int OFS_TXD  = 'h10;
  localparam int OFS_CTL1 = 'h20;
  localparam int OFS_CTL2 = 'h21;
  localparam int OFS_CTL3 = 'h22;
  localparam int OFS_FIFO = 'h24;
  localparam int OFS_STS1 = 'h25;
  localparam int OFS_STS2 = 'h26;
  localparam int OFS_BINC = 'h29;
  localparam int OFS_BMOD = 'h2A;
  localparam int OFS_MSEC = 'h2C;
  localparam int OFS_TEST = 'h2D;

  // bit positions other logic decodes
  localparam int STS1_RXRDY   = 9;
  localparam int STS1_TXRDY   = 13;
  localparam int STS2_DRDY    = 0;
  localparam int TEST_RXEMPTY = 5;
  localparam int CTL1_RXIE    = 9;
  localparam int CTL1_TXIE    = 13;
  localparam int CTL1_TXMTIE  = 6;
  localparam int CTL2_NRST    = 0;
  localparam int CTL2_TXEN    = 2;
  localparam int RXB_VALID    = 15;
  localparam int RXB_BREAK    = 11;

  // reset values and clear masks
  localparam logic [REG_W-1:0] STS1_RST  = 16'h6040;
  localparam logic [REG_W-1:0] STS2_RST  = 16'h4028;
  localparam logic [REG_W-1:0] TEST_RST  = 16'h0060;
  localparam logic [REG_W-1:0] CTL1_RST  = 16'h0000;
  localparam logic [REG_W-1:0] CTL2_RST  = 16'h0001;
  localparam logic [REG_W-1:0] CTL3_RST  = 16'h0700;
  localparam logic [REG_W-1:0] BINC_RST  = 16'h0004;
  localparam logic [REG_W-1:0] BMOD_RST  = 16'h0000;
  localparam logic [REG_W-1:0] RXB_RST   = 16'h4000;
  localparam logic [REG_W-1:0] STS1_W1C  = 16'h9DB0;
  localparam logic [REG_W-1:0] STS2_W1C  = 16'hBDD6;
  localparam logic [REG_W-1:0] RXB_BRKV  = REG_W'(1) << RXB_BREAK;

  typedef enum logic [3:0] {
    RD_ZERO, RD_RXD, RD_CTL1, RD_CTL2, RD_CTL3, RD_FIFO,
    RD_STS1, RD_STS2, RD_BINC, RD_BMOD, RD_MSEC, RD_TEST
  } rd_sel_e;

  typedef struct packed {
    logic rdEn;
    logic wrCtl1;
    logic wrCtl2;
    logic wrCtl3;
    logic wrFifo;
    logic wrBinc;
    logic wrBmod;
    logic wrMsec;
    logic clrSts1;
    logic clrSts2;
    logic softReset;
    logic rxConsume;
    logic rxAccept;
    logic txSend;
  } csr_strobe_t;

endpackage

// File: rtl/serial_csr_ctrl.sv
module serial_csr_ctrl
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              nrstBit,
  input  logic              rxStrobe,
  input  logic              rxEmpty,
  input  logic              rxFull,
  input  logic              txEnable,
  output csr_strobe_t       strobe,
  output rd_sel_e           rdSel
);

  logic isRead;
  logic isWrite;

  assign isRead  = busValid && !busWrite;
  assign isWrite = busValid && busWrite;

  always_comb begin
    strobe = '0;
    rdSel  = RD_ZERO;
    case (busAddr)
      ADDR_W'(OFS_RXD): begin
        rdSel            = RD_RXD;
        strobe.rxConsume = isRead && !rxEmpty;
      end
      ADDR_W'(OFS_TXD): strobe.txSend = isWrite && txEnable;
      ADDR_W'(OFS_CTL1): begin
        rdSel         = RD_CTL1;
        strobe.wrCtl1 = isWrite;
      end
      ADDR_W'(OFS_CTL2): begin
        rdSel            = RD_CTL2;
        strobe.wrCtl2    = isWrite;
        strobe.softReset = isWrite && !nrstBit;
      end
      ADDR_W'(OFS_CTL3): begin
        rdSel         = RD_CTL3;
        strobe.wrCtl3 = isWrite;
      end
      ADDR_W'(OFS_FIFO): begin
        rdSel         = RD_FIFO;
        strobe.wrFifo = isWrite;
      end
      ADDR_W'(OFS_STS1): begin
        rdSel          = RD_STS1;
        strobe.clrSts1 = isWrite;
      end
      ADDR_W'(OFS_STS2): begin
        rdSel          = RD_STS2;
        strobe.clrSts2 = isWrite;
      end
      ADDR_W'(OFS_BINC): begin
        rdSel         = RD_BINC;
        strobe.wrBinc = isWrite;
      end
      ADDR_W'(OFS_BMOD): begin
        rdSel         = RD_BMOD;
        strobe.wrBmod = isWrite;
      end
      ADDR_W'(OFS_MSEC): begin
        rdSel         = RD_MSEC;
        strobe.wrMsec = isWrite;
      end
      ADDR_W'(OFS_TEST): rdSel = RD_TEST;
      default: ;
    endcase
    strobe.rdEn     = isRead;
    // buffer full or a software reset in flight refuses the character
    strobe.rxAccept = rxStrobe && !rxFull && !strobe.softReset;
  end

  // R6: a full buffer never takes a character
  always_comb begin
    if (rxFull) p_no_accept_full_r6: assert (!strobe.rxAccept);
  end

endmodule

// File: rtl/serial_csr_dp.sv
module serial_csr_dp
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  rd_sel_e           rdSel,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CHAR_W-1:0] rxByte,
  input  logic              rxBreak,
  output logic [DATA_W-1:0] rdata,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  output logic              irq,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              txEnable
);

  logic [REG_W-1:0] ctl1, ctl2, ctl3, fifoCtl, baudInc, baudMod, oneMs;
  logic [REG_W-1:0] sts1, sts2, testReg, rxBuf;
  logic [REG_W-1:0] rdVal;
  logic [REG_W-1:0] rdyHits;

  // registers restored by power-on and by software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl1    <= CTL1_RST;
      ctl3    <= CTL3_RST;
      baudInc <= BINC_RST;
      baudMod <= BMOD_RST;
      sts1    <= STS1_RST;
      sts2    <= STS2_RST;
      testReg <= TEST_RST;
      rxBuf   <= RXB_RST;
    end else if (strobe.softReset) begin
      ctl1    <= CTL1_RST;
      ctl3    <= CTL3_RST;
      baudInc <= BINC_RST;
      baudMod <= BMOD_RST;
      sts1    <= STS1_RST;
      sts2    <= STS2_RST;
      testReg <= TEST_RST;
      rxBuf   <= RXB_RST;
    end else begin
      if (strobe.wrCtl1) ctl1    <= wdata;
      if (strobe.wrCtl3) ctl3    <= wdata;
      if (strobe.wrBinc) baudInc <= wdata;
      if (strobe.wrBmod) baudMod <= wdata;
      if (strobe.clrSts1) sts1 <= sts1 & ~(wdata & STS1_W1C);
      if (strobe.clrSts2) sts2 <= sts2 & ~(wdata & STS2_W1C);
      if (strobe.rxConsume) begin
        sts1[STS1_RXRDY]      <= 1'b0;
        sts2[STS2_DRDY]       <= 1'b0;
        testReg[TEST_RXEMPTY] <= 1'b1;
      end
      if (strobe.rxAccept) begin
        sts1[STS1_RXRDY]      <= 1'b1;
        sts2[STS2_DRDY]       <= 1'b1;
        testReg[TEST_RXEMPTY] <= 1'b0;
        rxBuf                 <= rxBreak ? RXB_BRKV : REG_W'(rxByte);
      end
    end
  end

  // registers untouched by software reset, and control 2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl2    <= CTL2_RST;
      fifoCtl <= '0;
      oneMs   <= '0;
    end else begin
      if (strobe.wrCtl2) ctl2 <= wdata | (REG_W'(1) << CTL2_NRST);
      if (strobe.wrFifo) fifoCtl <= wdata;
      if (strobe.wrMsec) oneMs   <= wdata;
    end
  end

  // transmit hand-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= strobe.txSend;
      if (strobe.txSend) txByte <= wdata[CHAR_W-1:0];
    end
  end

  always_comb begin
    case (rdSel)
      RD_RXD:  rdVal = rxBuf | (testReg[TEST_RXEMPTY] ? '0 : (REG_W'(1) << RXB_VALID));
      RD_CTL1: rdVal = ctl1;
      RD_CTL2: rdVal = ctl2;
      RD_CTL3: rdVal = ctl3;
      RD_FIFO: rdVal = fifoCtl;
      RD_STS1: rdVal = sts1;
      RD_STS2: rdVal = sts2;
      RD_BINC: rdVal = baudInc;
      RD_BMOD: rdVal = baudMod;
      RD_MSEC: rdVal = oneMs;
      RD_TEST: rdVal = testReg;
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (strobe.rdEn) rdata <= DATA_W'(rdVal);
  end

  assign rdyHits  = sts1 & ctl1;
  assign irq      = rdyHits[CTL1_RXIE] | (rdyHits[CTL1_TXIE] & ctl1[CTL1_TXMTIE]);
  assign rxEmpty  = testReg[TEST_RXEMPTY];
  assign rxFull   = sts1[STS1_RXRDY];
  assign txEnable = ctl2[CTL2_TXEN];

  // R3: an accepted character fills the buffer
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxAccept |=> (rxFull && !rxEmpty && sts2[STS2_DRDY]));

  // R5: a consuming read empties the buffer
  p_consume_empties_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxConsume |=> (rxEmpty && !rxFull && !sts2[STS2_DRDY]));

  // R6: a full buffer keeps its character until read or reset
  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !strobe.rxConsume && !strobe.softReset) |=> $stable(rxBuf));

  // R8: software reset restores state and leaves bit 0 of control 2 set
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softReset |=> (ctl2[CTL2_NRST] && ctl1 == CTL1_RST && testReg == TEST_RST));

  // R10: the transmit pulse follows exactly the send strobe
  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txSend |=> txValid);
  p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.txSend |=> !txValid);

  // R12: read data holds between reads
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdata));

endmodule

// File: rtl/serial_csr_top.sv
module serial_csr_top
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  input  logic              rxStrobe,
  input  logic              rxBreak,
  input  logic [CHAR_W-1:0] rxByte,
  output logic              rxReady,
  output logic              irq
);

  csr_strobe_t strobe;
  rd_sel_e     rdSel;
  logic        rxEmpty;
  logic        rxFull;
  logic        txEnable;

  generate
    if (DATA_W > REG_W) begin : g_wide
      logic unusedHighBits;
      assign unusedHighBits = ^busWdata[DATA_W-1:REG_W];
    end
  endgenerate

  serial_csr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .nrstBit  (busWdata[CTL2_NRST]),
    .rxStrobe (rxStrobe),
    .rxEmpty  (rxEmpty),
    .rxFull   (rxFull),
    .txEnable (txEnable),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  serial_csr_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wdata    (busWdata[REG_W-1:0]),
    .rxByte   (rxByte),
    .rxBreak  (rxBreak),
    .rdata    (busRdata),
    .txValid  (txValid),
    .txByte   (txByte),
    .irq      (irq),
    .rxEmpty  (rxEmpty),
    .rxFull   (rxFull),
    .txEnable (txEnable)
  );

  assign rxReady = !rxFull;

  // R3: a strobe taken while ready leaves the port not ready
  p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && rxReady && !(busValid && busWrite)) |=> !rxReady);

endmodule

// File: tb/serial_csr_top_tb_top.sv
module serial_csr_top_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int CHAR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              txValid;
  logic [CHAR_W-1:0] txByte;
  logic              rxStrobe = 1'b0;
  logic              rxBreak = 1'b0;
  logic [CHAR_W-1:0] rxByte = '0;
  logic              rxReady;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  serial_csr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txByte(txByte), .rxStrobe(rxStrobe),
    .rxBreak(rxBreak), .rxByte(rxByte), .rxReady(rxReady), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'h25, 32'h0, 32'h6040, 4'd1},   // R1 status 1
    '{1'b0, 6'h26, 32'h0, 32'h4028, 4'd1},   // R1 status 2
    '{1'b0, 6'h2D, 32'h0, 32'h0060, 4'd1},   // R1 test
    '{1'b0, 6'h21, 32'h0, 32'h0001, 4'd1},   // R1 control 2
    '{1'b0, 6'h22, 32'h0, 32'h0700, 4'd1},   // R1 control 3
    '{1'b0, 6'h29, 32'h0, 32'h0004, 4'd1},   // R1 baud increment
    '{1'b0, 6'h20, 32'h0, 32'h0000, 4'd1},   // R1 control 1
    '{1'b0, 6'h2A, 32'h0, 32'h0000, 4'd1},   // R1 modulator
    '{1'b0, 6'h00, 32'h0, 32'h4000, 4'd1},   // R1 empty buffer
    '{1'b1, 6'h22, 32'hDEADA5C3, 32'h0, 4'd2}, // R2 writes
    '{1'b0, 6'h22, 32'h0, 32'hA5C3, 4'd2},
    '{1'b1, 6'h24, 32'h12345678, 32'h0, 4'd2},
    '{1'b0, 6'h24, 32'h0, 32'h5678, 4'd2},
    '{1'b1, 6'h29, 32'hFFFF0102, 32'h0, 4'd2},
    '{1'b0, 6'h29, 32'h0, 32'h0102, 4'd2},
    '{1'b1, 6'h2A, 32'h0000BEEF, 32'h0, 4'd2},
    '{1'b0, 6'h2A, 32'h0, 32'hBEEF, 4'd2},
    '{1'b1, 6'h2C, 32'h80001357, 32'h0, 4'd2},
    '{1'b0, 6'h2C, 32'h0, 32'h1357, 4'd2},
    '{1'b1, 6'h20, 32'h00011234, 32'h0, 4'd2},
    '{1'b0, 6'h20, 32'h0, 32'h1234, 4'd2},
    '{1'b1, 6'h25, 32'h0000FFFF, 32'h0, 4'd7}, // R7 masks
    '{1'b0, 6'h25, 32'h0, 32'h6040, 4'd7},
    '{1'b1, 6'h26, 32'h0000FFFF, 32'h0, 4'd7},
    '{1'b0, 6'h26, 32'h0, 32'h4028, 4'd7},
    '{1'b1, 6'h2D, 32'h00000000, 32'h0, 4'd11}, // R11 unmapped
    '{1'b0, 6'h2D, 32'h0, 32'h0060, 4'd11},
    '{1'b1, 6'h23, 32'h0000FFFF, 32'h0, 4'd11},
    '{1'b0, 6'h23, 32'h0, 32'h0000, 4'd11},
    '{1'b0, 6'h2B, 32'h0, 32'h0000, 4'd11}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic rxSend(input logic [7:0] b, input logic brk);
    @(negedge clk);
    rxStrobe = 1'b1; rxBreak = brk; rxByte = b;
    @(negedge clk);
    rxStrobe = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic rdCheck(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    busRd(a, d);
    check(req, $sformatf("read 0x%0h", a), d, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 port state in and just after reset
    check("R1", "irq", 32'(irq), 32'h0);
    check("R1", "txValid", 32'(txValid), 32'h0);
    check("R1", "rxReady", 32'(rxReady), 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "rdata idle", busRdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) busWr(VECS[i].addr, VECS[i].data);
      else begin
        busRd(VECS[i].addr, d);
        check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), d, VECS[i].exp);
      end
    end

    // R12: read data holds without a read, and across a write
    @(negedge clk);
    check("R12", "hold idle", busRdata, 32'h0);
    busWr(6'h22, 32'h0700);
    check("R12", "hold across write", busRdata, 32'h0);
    busWr(6'h20, 32'h0);

    // R10: gated transmit
    busWr(6'h10, 32'h000000A7);
    check("R10", "tx while disabled", 32'(txValid), 32'h0);
    busWr(6'h21, 32'h0005);
    busWr(6'h10, 32'h000001C9);
    check("R10", "tx pulse", 32'(txValid), 32'h1);
    check("R10", "tx byte", 32'(txByte), 32'hC9);
    @(negedge clk);
    check("R10", "tx pulse ends", 32'(txValid), 32'h0);
    rdCheck(6'h25, 32'h6040, "R10");
    busWr(6'h21, 32'h0001);
    busWr(6'h10, 32'h00000055);
    check("R10", "tx after disable", 32'(txValid), 32'h0);

    // R3 and R5: receive then consume
    rxSend(8'h3C, 1'b0);
    check("R3", "rxReady low", 32'(rxReady), 32'h0);
    rdCheck(6'h25, 32'h6240, "R3");
    rdCheck(6'h26, 32'h4029, "R3");
    rdCheck(6'h2D, 32'h0040, "R3");
    rdCheck(6'h00, 32'h803C, "R5");
    check("R5", "rxReady back", 32'(rxReady), 32'h1);
    rdCheck(6'h25, 32'h6040, "R5");
    rdCheck(6'h26, 32'h4028, "R5");
    rdCheck(6'h2D, 32'h0060, "R5");
    rdCheck(6'h00, 32'h003C, "R5");

    // R4: break
    rxSend(8'h99, 1'b1);
    rdCheck(6'h00, 32'h8800, "R4");

    // R6: second strobe while full is dropped
    rxSend(8'h11, 1'b0);
    rxSend(8'h22, 1'b0);
    rdCheck(6'h00, 32'h8011, "R6");
    rdCheck(6'h00, 32'h0011, "R6");

    // R6/R5: consuming read and strobe in the same cycle
    rxSend(8'h33, 1'b0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 6'h00;
    rxStrobe = 1'b1; rxByte = 8'h55;
    @(negedge clk);
    busValid = 1'b0; rxStrobe = 1'b0;
    check("R5", "collision read", busRdata, 32'h8033);
    check("R6", "collision ready", 32'(rxReady), 32'h1);
    rdCheck(6'h00, 32'h0033, "R6");

    // R9: interrupt terms
    busWr(6'h20, 32'h0200);
    check("R9", "irq rx enabled, empty", 32'(irq), 32'h0);
    rxSend(8'h44, 1'b0);
    check("R9", "irq rx full", 32'(irq), 32'h1);
    rdCheck(6'h00, 32'h8044, "R9");
    check("R9", "irq after consume", 32'(irq), 32'h0);
    busWr(6'h20, 32'h2000);
    check("R9", "irq tx without empty enable", 32'(irq), 32'h0);
    busWr(6'h20, 32'h2040);
    check("R9", "irq tx gated on", 32'(irq), 32'h1);
    busWr(6'h20, 32'h0040);
    check("R9", "irq empty enable only", 32'(irq), 32'h0);

    // R8: software reset, with a strobe in the same cycle
    busWr(6'h22, 32'h1111);
    busWr(6'h2A, 32'h2222);
    busWr(6'h29, 32'h3333);
    busWr(6'h24, 32'h4444);
    busWr(6'h20, 32'h2040);
    rxSend(8'h77, 1'b0);
    rdCheck(6'h00, 32'h8077, "R8");
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 6'h21; busWdata = 32'h0006;
    rxStrobe = 1'b1; rxByte = 8'h66;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; rxStrobe = 1'b0;
    check("R8", "irq after reset", 32'(irq), 32'h0);
    check("R8", "rxReady after reset", 32'(rxReady), 32'h1);
    rdCheck(6'h21, 32'h0007, "R8");
    rdCheck(6'h20, 32'h0000, "R8");
    rdCheck(6'h22, 32'h0700, "R8");
    rdCheck(6'h29, 32'h0004, "R8");
    rdCheck(6'h2A, 32'h0000, "R8");
    rdCheck(6'h24, 32'h4444, "R8");
    rdCheck(6'h2C, 32'h1357, "R8");
    rdCheck(6'h25, 32'h6040, "R8");
    rdCheck(6'h26, 32'h4028, "R8");
    rdCheck(6'h2D, 32'h0060, "R8");
    rdCheck(6'h00, 32'h4000, "R8");
    busWr(6'h10, 32'h0000005A);
    check("R8", "tx enabled by written value", 32'(txValid), 32'h1);
    check("R8", "tx byte", 32'(txByte), 32'h5A);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule